// File: doc/BRIEF.md
# Dual Multiply-Accumulate Unit with Guard-Bit Accumulators

The block holds two multiply-accumulate lanes that run side by side. Each lane takes its own pair of 16-bit operands and its own operation code. It forms the product in a first pipeline stage, then applies the product to a 40-bit accumulator in a second stage. The 8 bits above a 32-bit product act as guard bits, so long sums can run without wrapping. A new operation may enter every cycle on both lanes at once.

Mode inputs are shared by both lanes and are captured with the operands, so they travel down the pipeline with their operation. They choose signed or unsigned operands, fractional or integer scaling, and saturating or wrapping accumulation. Each lane always presents three forms of its accumulator: the full 40-bit value, a 16-bit upper word that is rounded and saturated, and a 32-bit word that is saturated. Each lane also has a sticky overflow flag.

The unit sits behind an instruction decoder and a register file, which are not part of it.

Top module: `dual_mac`

## Requirements
- R1: An operation accepted with `in_valid` high at clock edge k shows its effect on the accumulator outputs after edge k+2. `out_valid` is high for exactly the cycle after edge k+2 and stays low when nothing was accepted two edges earlier. Operations may be accepted on consecutive cycles.
- R2: Operation codes are per lane. 2'b00 loads the product, 2'b01 adds the product to the accumulator, 2'b10 subtracts the product from the accumulator, and 2'b11 clears the accumulator to zero. With `in_valid` low, the accumulators keep their value. Reset clears the accumulators, the flags and `out_valid`.
- R3: With `signed_en` = 1, the operands are two's complement. With `signed_en` = 0, they are unsigned. In both cases the accumulator is treated as a signed 40-bit number.
- R4: With `frac_en` = 1, the product is doubled. In signed fractional mode, 0x8000 times 0x8000 gives 0x7FFFFFFF instead of 2^31.
- R5: When an add or subtract result falls outside the signed 40-bit range, the accumulator clamps to 0x7FFFFFFFFF or 0x8000000000 if `sat_en` = 1. If `sat_en` = 0, it keeps the low 40 bits.
- R6: A lane's overflow flag is set on the edge where a clamp of R5 happens. Only a high `ovf_clr` at an edge clears it, and a new clamp at that same edge wins. The clear operation code does not clear the flag.
- R7: `hiN` is bits 39..16 of the accumulator, rounded on bits 15..0 and then saturated to the signed 16-bit range. A remainder above 0x8000 rounds up and one below rounds down. A remainder of exactly 0x8000 rounds up when `rnd_even` = 0. When `rnd_even` = 1, it rounds to the value whose least significant bit is zero. `rnd_even` acts on the outputs immediately.
- R8: `wideN` is the accumulator saturated to the signed 32-bit range: 0x7FFFFFFF above it and 0x80000000 below it.
- R9: The two lanes are independent. Operands, operation code, accumulator, flag and extractions of one lane never affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept an operation on both lanes |
| op0 | input | 2 | Lane 0 operation code |
| op1 | input | 2 | Lane 1 operation code |
| a0 | input | 16 | Lane 0 first operand |
| b0 | input | 16 | Lane 0 second operand |
| a1 | input | 16 | Lane 1 first operand |
| b1 | input | 16 | Lane 1 second operand |
| signed_en | input | 1 | Two's complement operands |
| frac_en | input | 1 | Fractional scaling |
| sat_en | input | 1 | Saturating accumulation |
| rnd_even | input | 1 | Ties-to-even rounding on upper-word extraction |
| ovf_clr | input | 1 | Clear both sticky overflow flags |
| out_valid | output | 1 | Accumulators just updated |
| acc0 | output | 40 | Lane 0 accumulator |
| acc1 | output | 40 | Lane 1 accumulator |
| hi0 | output | 16 | Lane 0 rounded, saturated upper word |
| hi1 | output | 16 | Lane 1 rounded, saturated upper word |
| wide0 | output | 32 | Lane 0 saturated 32-bit word |
| wide1 | output | 32 | Lane 1 saturated 32-bit word |
| ovf0 | output | 1 | Lane 0 sticky overflow |
| ovf1 | output | 1 | Lane 1 sticky overflow |

## Verification
The hardest state to reach is 40-bit saturation: the guard bits absorb 256 full-scale products before a clamp can happen. The stimulus reaches it by streaming the signed fractional -1 by -1 product every cycle for more than 257 cycles, with lane 0 adding and lane 1 subtracting. Both clamps, and the sticky flags with their clear, are exercised in that one run. The same run is repeated with saturation off to show wrapping. The ties of the rounding rule need remainders of exactly 0x8000, so products of multiples of 0x4000 are loaded.

// File: rtl/dual_mac_pkg.sv
package dual_mac_pkg;

  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_CLR  = 2'b11
  } mac_op_e;

endpackage

// File: rtl/mac_mult.sv
module mac_mult
  import dual_mac_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            en_i,
  input  mac_op_e         op_i,
  input  logic [OPW-1:0]  a_i,
  input  logic [OPW-1:0]  b_i,
  input  logic            signed_i,
  input  logic            frac_i,
  input  logic            sat_i,
  output logic            vld_o,
  output mac_op_e         op_o,
  output logic            sat_o,
  output logic [ACCW-1:0] prod_o
);

  localparam int PW = 2 * OPW + 2;
  localparam logic [OPW-1:0]  OP_MIN = {1'b1, {(OPW-1){1'b0}}};
  localparam logic [ACCW-1:0] P_MAX  = {{(ACCW-2*OPW+1){1'b0}}, {(2*OPW-1){1'b1}}};

  logic signed [OPW:0]  ax, bx;
  logic signed [PW-1:0] raw;
  logic [ACCW-1:0]      ext, prod_d;
  logic                 minmin;

  always_comb begin
    ax     = {signed_i & a_i[OPW-1], a_i};
    bx     = {signed_i & b_i[OPW-1], b_i};
    raw    = ax * bx;
    ext    = {{(ACCW-PW){raw[PW-1]}}, raw};
    minmin = signed_i && frac_i && (a_i == OP_MIN) && (b_i == OP_MIN);
    if (minmin) begin
      prod_d = P_MAX;
    end else if (frac_i) begin
      prod_d = ext << 1;
    end else begin
      prod_d = ext;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      op_o   <= OP_LOAD;
      sat_o  <= 1'b0;
      prod_o <= '0;
    end else begin
      vld_o <= en_i;
      if (en_i) begin
        op_o   <= op_i;
        sat_o  <= sat_i;
        prod_o <= prod_d;
      end
    end
  end

  AST_FRAC_MINMIN: assert property (@(posedge clk) disable iff (!rst_ni)
    en_i && signed_i && frac_i && a_i == OP_MIN && b_i == OP_MIN |=> prod_o == P_MAX); // R4

endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import dual_mac_pkg::*;
#(
  parameter int ACCW = 40
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            vld_i,
  input  mac_op_e         op_i,
  input  logic            sat_i,
  input  logic [ACCW-1:0] prod_i,
  input  logic            ovf_clr_i,
  output logic            vld_o,
  output logic [ACCW-1:0] acc_o,
  output logic            ovf_o
);

  localparam logic [ACCW-1:0] A_MAX = {1'b0, {(ACCW-1){1'b1}}};
  localparam logic [ACCW-1:0] A_MIN = {1'b1, {(ACCW-1){1'b0}}};

  logic [ACCW:0]   acc_x, prod_x, sum;
  logic            over, clamp;
  logic [ACCW-1:0] acc_d;
  logic            ovf_d;

  always_comb begin
    acc_x  = {acc_o[ACCW-1], acc_o};
    prod_x = {prod_i[ACCW-1], prod_i};
    unique case (op_i)
      OP_LOAD: sum = prod_x;
      OP_ADD:  sum = acc_x + prod_x;
      OP_SUB:  sum = acc_x - prod_x;
      default: sum = '0;
    endcase
    over  = sum[ACCW] != sum[ACCW-1];
    clamp = vld_i && sat_i && over;
    if (!vld_i) begin
      acc_d = acc_o;
    end else if (clamp) begin
      acc_d = sum[ACCW] ? A_MIN : A_MAX;
    end else begin
      acc_d = sum[ACCW-1:0];
    end
    ovf_d = (ovf_o & ~ovf_clr_i) | clamp;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      acc_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      acc_o <= acc_d;
      ovf_o <= ovf_d;
    end
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !vld_i |=> $stable(acc_o)); // R2
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    vld_i && op_i == OP_CLR |=> acc_o == '0); // R2
  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ovf_o) |-> (acc_o == A_MAX || acc_o == A_MIN)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    ovf_o && !ovf_clr_i |=> ovf_o); // R6

endmodule

// File: rtl/mac_extract.sv
module mac_extract #(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic [ACCW-1:0]  acc_i,
  input  logic             rnd_even_i,
  output logic [OPW-1:0]   hi_o,
  output logic [2*OPW-1:0] wide_o
);

  localparam int QW = ACCW - OPW;
  localparam logic [OPW-1:0]         HALF = {1'b1, {(OPW-1){1'b0}}};
  localparam logic signed [QW:0]     HMAX = {{(QW+1-OPW){1'b0}}, 1'b0, {(OPW-1){1'b1}}};
  localparam logic signed [QW:0]     HMIN = ~HMAX;
  localparam logic signed [ACCW-1:0] WMAX = {{(ACCW-2*OPW+1){1'b0}}, {(2*OPW-1){1'b1}}};
  localparam logic signed [ACCW-1:0] WMIN = ~WMAX;

  logic [QW-1:0]     q;
  logic [OPW-1:0]    rem;
  logic              up;
  logic signed [QW:0] qr;

  always_comb begin
    q   = acc_i[ACCW-1:OPW];
    rem = acc_i[OPW-1:0];
    up  = (rem > HALF) || ((rem == HALF) && (!rnd_even_i || q[0]));
    qr  = $signed({q[QW-1], q}) + $signed({{QW{1'b0}}, up});
    if (qr > HMAX) begin
      hi_o = HMAX[OPW-1:0];
    end else if (qr < HMIN) begin
      hi_o = HMIN[OPW-1:0];
    end else begin
      hi_o = qr[OPW-1:0];
    end
    if ($signed(acc_i) > WMAX) begin
      wide_o = WMAX[2*OPW-1:0];
    end else if ($signed(acc_i) < WMIN) begin
      wide_o = WMIN[2*OPW-1:0];
    end else begin
      wide_o = acc_i[2*OPW-1:0];
    end
  end

  always_comb begin
    if (acc_i[ACCW-1]) begin
      AST_HI_SIGN: assert (hi_o[OPW-1] || hi_o == '0); // R7
    end
    AST_WIDE_SIGN: assert (wide_o[2*OPW-1] == acc_i[ACCW-1]); // R8
  end

endmodule

// File: rtl/dual_mac.sv
module dual_mac
  import dual_mac_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      op0,
  input  logic [1:0]      op1,
  input  logic [OPW-1:0]  a0,
  input  logic [OPW-1:0]  b0,
  input  logic [OPW-1:0]  a1,
  input  logic [OPW-1:0]  b1,
  input  logic            signed_en,
  input  logic            frac_en,
  input  logic            sat_en,
  input  logic            rnd_even,
  input  logic            ovf_clr,
  output logic            out_valid,
  output logic [ACCW-1:0] acc0,
  output logic [ACCW-1:0] acc1,
  output logic [OPW-1:0]  hi0,
  output logic [OPW-1:0]  hi1,
  output logic [2*OPW-1:0] wide0,
  output logic [2*OPW-1:0] wide1,
  output logic            ovf0,
  output logic            ovf1
);

  localparam int NLANE = 2;

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i = rst_sync_q[1];

  logic [1:0]      op_l   [NLANE];
  logic [OPW-1:0]  a_l    [NLANE];
  logic [OPW-1:0]  b_l    [NLANE];
  logic            vld1_l [NLANE];
  mac_op_e         op1_l  [NLANE];
  logic            sat1_l [NLANE];
  logic [ACCW-1:0] prod_l [NLANE];
  logic            vld2_l [NLANE];
  logic [ACCW-1:0] acc_l  [NLANE];
  logic            ovf_l  [NLANE];
  logic [OPW-1:0]  hi_l   [NLANE];
  logic [2*OPW-1:0] wide_l [NLANE];

  assign op_l[0] = op0;
  assign op_l[1] = op1;
  assign a_l[0]  = a0;
  assign a_l[1]  = a1;
  assign b_l[0]  = b0;
  assign b_l[1]  = b1;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    mac_mult #(.OPW(OPW), .ACCW(ACCW)) u_mult (
      .clk      (clk),
      .rst_ni   (rst_i),
      .en_i     (in_valid),
      .op_i     (mac_op_e'(op_l[g])),
      .a_i      (a_l[g]),
      .b_i      (b_l[g]),
      .signed_i (signed_en),
      .frac_i   (frac_en),
      .sat_i    (sat_en),
      .vld_o    (vld1_l[g]),
      .op_o     (op1_l[g]),
      .sat_o    (sat1_l[g]),
      .prod_o   (prod_l[g])
    );

    mac_accum #(.ACCW(ACCW)) u_accum (
      .clk       (clk),
      .rst_ni    (rst_i),
      .vld_i     (vld1_l[g]),
      .op_i      (op1_l[g]),
      .sat_i     (sat1_l[g]),
      .prod_i    (prod_l[g]),
      .ovf_clr_i (ovf_clr),
      .vld_o     (vld2_l[g]),
      .acc_o     (acc_l[g]),
      .ovf_o     (ovf_l[g])
    );

    mac_extract #(.OPW(OPW), .ACCW(ACCW)) u_extract (
      .acc_i      (acc_l[g]),
      .rnd_even_i (rnd_even),
      .hi_o       (hi_l[g]),
      .wide_o     (wide_l[g])
    );
  end

  assign out_valid = vld2_l[0];
  assign acc0  = acc_l[0];
  assign acc1  = acc_l[1];
  assign hi0   = hi_l[0];
  assign hi1   = hi_l[1];
  assign wide0 = wide_l[0];
  assign wide1 = wide_l[1];
  assign ovf0  = ovf_l[0];
  assign ovf1  = ovf_l[1];

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_i)
    in_valid |-> ##2 out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_i)
    !in_valid |-> ##2 !out_valid); // R1
  AST_LANE_ALIGN: assert property (@(posedge clk) disable iff (!rst_i)
    vld2_l[0] == vld2_l[1]); // R9

endmodule

// File: tb/dual_mac_tb.sv
module dual_mac_tb;

  localparam time TCLK = 10ns;
  localparam longint A_MAX = 64'sd549755813887;
  localparam longint A_MIN = -64'sd549755813888;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op0, op1;
  logic [15:0] a0, b0, a1, b1;
  logic        signed_en, frac_en, sat_en, rnd_even, ovf_clr;
  logic        out_valid;
  logic [39:0] acc0, acc1;
  logic [15:0] hi0, hi1;
  logic [31:0] wide0, wide1;
  logic        ovf0, ovf1;

  dual_mac u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op0(op0), .op1(op1),
    .a0(a0), .b0(b0), .a1(a1), .b1(b1), .signed_en(signed_en),
    .frac_en(frac_en), .sat_en(sat_en), .rnd_even(rnd_even), .ovf_clr(ovf_clr),
    .out_valid(out_valid), .acc0(acc0), .acc1(acc1), .hi0(hi0), .hi1(hi1),
    .wide0(wide0), .wide1(wide1), .ovf0(ovf0), .ovf1(ovf1)
  );

  always #(TCLK/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_tag = "R2 reset";

  // reference state
  longint m_acc [2];
  bit     m_ovf [2];
  bit     m_vld;
  bit     p_v;
  logic [1:0]  p_op [2];
  logic [15:0] p_a [2];
  logic [15:0] p_b [2];
  bit     p_s, p_f, p_sat;

  task automatic chk(string tag, longint got, longint exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic longint mprod(logic [15:0] a, logic [15:0] b, bit s, bit f);
    longint x, y, p;
    x = s ? longint'($signed(a)) : longint'(a);
    y = s ? longint'($signed(b)) : longint'(b);
    p = x * y;
    if (f) begin
      if (s && a == 16'h8000 && b == 16'h8000) p = 64'sh7FFFFFFF;
      else p = p * 2;
    end
    return p;
  endfunction

  function automatic longint mhi(longint v, bit even);
    longint q, r;
    q = v >>> 16;
    r = v & 64'hFFFF;
    if (r > 32768 || (r == 32768 && (!even || q[0]))) q = q + 1;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  function automatic longint mwide(longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  task automatic model_edge();
    longint p, r;
    bit ev;
    m_vld = p_v;
    for (int l = 0; l < 2; l++) begin
      ev = 0;
      if (p_v) begin
        p = mprod(p_a[l], p_b[l], p_s, p_f);
        case (p_op[l])
          2'b00: r = p;
          2'b01: r = m_acc[l] + p;
          2'b10: r = m_acc[l] - p;
          default: r = 0;
        endcase
        if (r > A_MAX || r < A_MIN) begin
          if (p_sat) begin
            r = (r > A_MAX) ? A_MAX : A_MIN;
            ev = 1;
          end else begin
            r = r & 64'hFF_FFFF_FFFF;
            if (r > A_MAX) r = r - 64'sd1099511627776;
          end
        end
        m_acc[l] = r;
      end
      m_ovf[l] = (m_ovf[l] && !ovf_clr) || ev;
    end
    p_v = in_valid; p_s = signed_en; p_f = frac_en; p_sat = sat_en;
    p_op[0] = op0; p_op[1] = op1;
    p_a[0] = a0; p_a[1] = a1; p_b[0] = b0; p_b[1] = b1;
  endtask

  task automatic check_all();
    chk("R1 out_valid", longint'(out_valid), longint'(m_vld));
    chk({cur_tag, " acc0"}, longint'($signed(acc0)), m_acc[0]);
    chk({"R9 ", cur_tag, " acc1"}, longint'($signed(acc1)), m_acc[1]);
    chk("R7 hi0", longint'($signed(hi0)), mhi(m_acc[0], rnd_even));
    chk("R7 hi1", longint'($signed(hi1)), mhi(m_acc[1], rnd_even));
    chk("R8 wide0", longint'($signed(wide0)), mwide(m_acc[0]));
    chk("R8 wide1", longint'($signed(wide1)), mwide(m_acc[1]));
    chk("R6 ovf0", longint'(ovf0), longint'(m_ovf[0]));
    chk("R6 ovf1", longint'(ovf1), longint'(m_ovf[1]));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  task automatic issue(logic [1:0] o0, logic [15:0] x0, logic [15:0] y0,
                       logic [1:0] o1, logic [15:0] x1, logic [15:0] y1);
    in_valid = 1; op0 = o0; a0 = x0; b0 = y0; op1 = o1; a1 = x1; b1 = y1;
    cyc();
    in_valid = 0;
  endtask

  task automatic idle(int n);
    in_valid = 0;
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; op0 = 0; op1 = 0; a0 = 0; b0 = 0; a1 = 0; b1 = 0;
    signed_en = 1; frac_en = 0; sat_en = 0; rnd_even = 0; ovf_clr = 0;
    m_acc[0] = 0; m_acc[1] = 0; m_ovf[0] = 0; m_ovf[1] = 0; m_vld = 0; p_v = 0;
    for (int l = 0; l < 2; l++) begin p_op[l] = 0; p_a[l] = 0; p_b[l] = 0; end
    p_s = 0; p_f = 0; p_sat = 0;
    repeat (3) @(negedge clk);
    check_all();               // R2 reset state
    rst_n = 1;
    repeat (4) @(negedge clk);

    cur_tag = "R2 ops";
    issue(2'b00, 16'd3, 16'd4, 2'b00, 16'hFFFB, 16'd7);
    issue(2'b01, 16'd10, 16'd10, 2'b10, 16'd2, 16'd3);
    issue(2'b10, 16'd5, 16'd30, 2'b01, 16'hFFFF, 16'hFFFF);
    idle(3);
    issue(2'b11, 16'd1, 16'd1, 2'b01, 16'd9, 16'd9);
    idle(3);

    cur_tag = "R3 unsigned";
    signed_en = 0;
    issue(2'b00, 16'hFFFF, 16'hFFFF, 2'b00, 16'h8000, 16'h0002);
    signed_en = 1;
    issue(2'b00, 16'hFFFF, 16'hFFFF, 2'b00, 16'h8000, 16'h0002);
    idle(2);

    cur_tag = "R4 frac";
    frac_en = 1;
    issue(2'b00, 16'h8000, 16'h8000, 2'b00, 16'h4000, 16'h4000);
    issue(2'b00, 16'h7FFF, 16'h7FFF, 2'b00, 16'h8000, 16'h7FFF);
    signed_en = 0;
    issue(2'b00, 16'h8000, 16'h8000, 2'b00, 16'hFFFF, 16'hFFFF);
    signed_en = 1; frac_en = 0;
    idle(2);

    cur_tag = "R7 ties";
    for (int e = 0; e < 2; e++) begin
      rnd_even = e[0];
      issue(2'b00, 16'd6, 16'h4000, 2'b00, 16'd10, 16'h4000);
      idle(2);
      issue(2'b00, 16'hFFFA, 16'h4000, 2'b00, 16'hFFF6, 16'h4000);
      idle(2);
      rnd_even = ~rnd_even;
      cyc();
    end

    cur_tag = "R5 saturate";
    signed_en = 1; frac_en = 1; sat_en = 1;
    issue(2'b11, 0, 0, 2'b11, 0, 0);
    in_valid = 1; op0 = 2'b01; op1 = 2'b10;
    a0 = 16'h8000; b0 = 16'h8000; a1 = 16'h8000; b1 = 16'h8000;
    for (int i = 0; i < 262; i++) cyc();
    cur_tag = "R6 sticky";
    in_valid = 1; op0 = 2'b11; op1 = 2'b11;
    cyc();
    in_valid = 0;
    idle(3);
    ovf_clr = 1; cyc(); ovf_clr = 0;
    idle(2);

    cur_tag = "R5 wrap";
    sat_en = 0;
    in_valid = 1; op0 = 2'b01; op1 = 2'b10;
    for (int i = 0; i < 262; i++) cyc();
    idle(3);

    cur_tag = "R9 random";
    for (int i = 0; i < 500; i++) begin
      in_valid = ($urandom % 4) != 0;
      op0 = 2'($urandom); op1 = 2'($urandom);
      a0 = 16'($urandom); b0 = 16'($urandom);
      a1 = 16'($urandom); b1 = 16'($urandom);
      signed_en = 1'($urandom); frac_en = 1'($urandom);
      sat_en = 1'($urandom); rnd_even = 1'($urandom);
      ovf_clr = ($urandom % 16) == 0;
      cyc();
    end
    ovf_clr = 0;
    idle(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule